// File: doc/BRIEF.md
# Key-Protected Programmable Watchdog Timer

This block guards a system against software that has stopped making progress. A free-running prescaler divides the master clock by one of four selectable powers of two. Each divided tick decrements a down counter that software must restart at regular intervals. If the counter passes zero, the block reloads it at once and fires any mix of three overflow actions: a one-cycle internal reset request, a one-cycle interrupt pulse, and an active-low external overflow line held low for a fixed number of master-clock cycles.

Software reaches three registers through a synchronous write port: a mode register, a clock register and a control register. A write changes state only when its upper twelve bits hold the access key. The restart command is a keyed control write that carries a specific code. The reload value is programmable only in its top bits. The bits below them are always ones, so even the shortest setting leaves a useful timeout. With the default dividers of 32, 128, 1024 and 4096 and a 33 MHz clock, the timeout ranges from about 4 ms to about 8 s.

Top module: `keyed_wdt`

## Requirements
- R1: After reset the watchdog is stopped and all three outputs are inactive: `wd_rst_o`=0, `wd_irq_o`=0, `wd_ext_n_o`=1.
- R2: A write whose `wr_data[31:20]` differs from 12'hD3A changes no register and issues no restart.
- R3: `wr_sel` 0 writes the mode register (bit0 run, bit1 reset enable, bit2 interrupt enable, bit3 external enable). `wr_sel` 1 writes the clock register (bits 1:0 source select, bits 2+HI_W-1:2 high preload). `wr_sel` 2 is the control register, where `wr_data[7:0]`=8'hA5 means restart.
- R4: A restart loads the counter with the high preload in its top HI_W bits and ones in every lower bit.
- R5: Source select s gives one tick every 2^DIV_LOG[s] master cycles. The first overflow action appears exactly (reload+1)*2^DIV_LOG[s] cycles after the restart write.
- R6: On overflow the counter reloads and keeps running, so overflow actions repeat once per full timeout period.
- R7: While run is 0, the counter and the prescaler hold their values and no overflow occurs. Time spent stopped delays the next overflow by exactly that many cycles.
- R8: With reset enable set, each overflow raises `wd_rst_o` for exactly one cycle.
- R9: With interrupt enable set, each overflow raises `wd_irq_o` for exactly one cycle. With interrupt enable clear, it stays 0.
- R10: With external enable set, each overflow drives `wd_ext_n_o` low for exactly EXT_LEN (8) cycles.
- R11: A keyed restart before overflow starts a full new period. A keyed control write with any code other than 8'hA5 has no effect on timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 mode, 1 clock, 2 control |
| wr_data | input | 32 | Write data; bits 31:20 carry the access key |
| wd_rst_o | output | 1 | Internal reset request pulse |
| wd_irq_o | output | 1 | Interrupt pulse |
| wd_ext_n_o | output | 1 | Active-low external overflow line |

## Verification
The bench runs the block with a small counter and dividers of 1, 2, 4 and 8. It sweeps every source select against every high preload value, which separates a wrong divider from a wrong reload, and it measures the first and second periods so that a broken automatic reload shows up. Several patterns then isolate the write path: writes with a bad key, a control write with the wrong code, an early restart, and a run-stop-run sequence whose expected delay is worked out edge by edge. A final run enables only the reset and external outputs, and checks the length of each pulse and that the interrupt stays silent.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int          DATA_W       = 32;
    localparam int          KEY_LSB      = 20;
    localparam logic [11:0] ACCESS_KEY   = 12'hD3A;
    localparam logic [7:0]  RESTART_CODE = 8'hA5;

    typedef enum logic [1:0] {
        SEL_MODE  = 2'd0,
        SEL_CLOCK = 2'd1,
        SEL_CTRL  = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic ext_en;
        logic irq_en;
        logic rst_en;
        logic run;
    } mode_t;

    function automatic logic key_ok(input logic [DATA_W-1:0] d);
        return d[DATA_W-1:KEY_LSB] == ACCESS_KEY;
    endfunction

    function automatic mode_t mode_from(input logic [DATA_W-1:0] d);
        return mode_t'(d[3:0]);
    endfunction

    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int HI_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output mode_t             mode_o,
    output logic [1:0]        src_o,
    output logic [HI_W-1:0]   hi_o,
    output logic              restart_o
);

    logic     accept;
    reg_sel_e sel;
    logic     unused_bits;

    assign sel         = reg_sel_e'(wr_sel);
    assign accept      = wr_en && key_ok(wr_data);
    assign unused_bits = ^wr_data[KEY_LSB-1:8];
    assign restart_o   = accept && (sel == SEL_CTRL) && (wr_data[7:0] == RESTART_CODE);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_o <= '0;
            src_o  <= 2'd3;
            hi_o   <= '1;
        end else if (accept) begin
            case (sel)
                SEL_MODE:  mode_o <= mode_from(wr_data);
                SEL_CLOCK: begin
                    src_o <= wr_data[1:0];
                    hi_o  <= wr_data[2+HI_W-1:2];
                end
                default: ;
            endcase
        end
    end

    // R2
    bad_key_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !key_ok(wr_data)) |=> ($stable(mode_o) && $stable(src_o) && $stable(hi_o)));

endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
    import wdt_pkg::*;
#(
    parameter int DIV_LOG [4] = '{5, 7, 10, 12}
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic       restart,
    input  logic [1:0] src,
    output logic       tick_o
);

    localparam int PW = max4(DIV_LOG[0], DIV_LOG[1], DIV_LOG[2], DIV_LOG[3]) + 1;

    logic [PW-1:0] pre_q;
    logic [3:0]    match;

    for (genvar g = 0; g < 4; g++) begin : g_src
        localparam logic [PW-1:0] MASK = PW'((64'd1 << DIV_LOG[g]) - 64'd1);
        assign match[g] = (pre_q & MASK) == MASK;
    end

    assign tick_o = run && match[src];

    always_ff @(posedge clk) begin
        if (rst || restart) pre_q <= '0;
        else if (run)       pre_q <= pre_q + 1'b1;
    end

    // R7
    pre_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!run && !restart) |=> $stable(pre_q));

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             tick,
    input  logic             restart,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ovf_o
);

    assign ovf_o = tick && !restart && (cnt_o == '0);

    always_ff @(posedge clk) begin
        if (rst)           cnt_o <= '1;
        else if (restart)  cnt_o <= reload;
        else if (tick)     cnt_o <= (cnt_o == '0) ? reload : cnt_o - 1'b1;
    end

    // R7
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!run && !restart) |=> $stable(cnt_o));

    // R6
    auto_reload_chk: assert property (@(posedge clk) disable iff (rst)
        ovf_o |=> (cnt_o == $past(reload)));

endmodule

// File: rtl/wdt_outputs.sv
module wdt_outputs
    import wdt_pkg::*;
#(
    parameter int EXT_LEN = 8
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  ovf,
    input  mode_t mode,
    output logic  rst_o,
    output logic  irq_o,
    output logic  ext_n_o
);

    localparam int EW = $clog2(EXT_LEN + 1);

    logic [EW-1:0] ext_q;

    assign ext_n_o = (ext_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            rst_o <= 1'b0;
            irq_o <= 1'b0;
            ext_q <= '0;
        end else begin
            rst_o <= ovf && mode.rst_en;
            irq_o <= ovf && mode.irq_en;
            if (ovf && mode.ext_en) ext_q <= EW'(EXT_LEN);
            else if (ext_q != '0)   ext_q <= ext_q - 1'b1;
        end
    end

    // R8
    rst_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rst_o |=> !rst_o);

    // R9
    irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o |=> !irq_o);

    // R10
    ext_start_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ext_n_o) |-> $past(ovf && mode.ext_en));

endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
    import wdt_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int HI_W        = 4,
    parameter int DIV_LOG [4] = '{5, 7, 10, 12},
    parameter int EXT_LEN     = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [31:0] wr_data,
    output logic        wd_rst_o,
    output logic        wd_irq_o,
    output logic        wd_ext_n_o
);

    localparam int LOW_W = CNT_W - HI_W;

    mode_t             mode;
    logic [1:0]        src;
    logic [HI_W-1:0]   hi;
    logic              restart;
    logic              tick;
    logic [CNT_W-1:0]  reload;
    logic [CNT_W-1:0]  cnt;
    logic              ovf;

    assign reload = {hi, {LOW_W{1'b1}}};

    wdt_regs #(.HI_W(HI_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .mode_o(mode), .src_o(src), .hi_o(hi), .restart_o(restart)
    );

    wdt_prescaler #(.DIV_LOG(DIV_LOG)) u_pre (
        .clk(clk), .rst(rst), .run(mode.run), .restart(restart), .src(src), .tick_o(tick)
    );

    wdt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .run(mode.run), .tick(tick), .restart(restart),
        .reload(reload), .cnt_o(cnt), .ovf_o(ovf)
    );

    wdt_outputs #(.EXT_LEN(EXT_LEN)) u_out (
        .clk(clk), .rst(rst), .ovf(ovf), .mode(mode),
        .rst_o(wd_rst_o), .irq_o(wd_irq_o), .ext_n_o(wd_ext_n_o)
    );

    // R4
    reload_chk: assert property (@(posedge clk) disable iff (rst)
        restart |=> (cnt == {$past(hi), {LOW_W{1'b1}}}));

endmodule

// File: tb/test_keyed_wdt.sv
module test_keyed_wdt;

    localparam int CNT_W = 6;
    localparam int HI_W  = 2;
    localparam int LOWN  = 1 << (CNT_W - HI_W);

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = 32'd0;
    logic        wd_rst_o, wd_irq_o, wd_ext_n_o;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    keyed_wdt #(.CNT_W(CNT_W), .HI_W(HI_W), .DIV_LOG('{0, 1, 2, 3}), .EXT_LEN(8)) i_keyed_wdt (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .wd_rst_o(wd_rst_o), .wd_irq_o(wd_irq_o), .wd_ext_n_o(wd_ext_n_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [11:0] key, input logic [19:0] payload);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_sel  = sel;
        wr_data = {key, payload};
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic restart();
        wr(2'd2, 12'hD3A, 20'h000A5);
    endtask

    task automatic wait_irq(input int limit, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!wd_irq_o && n < limit);
    endtask

    initial begin
        #(150000 * 5);
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        int n, m, irqs, exts, rsts, first_rst, first_ext;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 rst_o", int'(wd_rst_o), 0);
        chk("R1 irq_o", int'(wd_irq_o), 0);
        chk("R1 ext_n_o", int'(wd_ext_n_o), 1);

        // R2 bad-key mode write must not start the watchdog
        wr(2'd0, 12'hD3B, 20'h0000F);
        wr(2'd1, 12'h000, 20'h00000);
        irqs = 0; exts = 0; rsts = 0;
        for (int i = 0; i < 700; i++) begin
            @(negedge clk);
            irqs += int'(wd_irq_o);
            rsts += int'(wd_rst_o);
            exts += int'(!wd_ext_n_o);
        end
        chk("R2 R1 no irq after bad key", irqs, 0);
        chk("R2 R1 no rst after bad key", rsts, 0);
        chk("R2 R1 no ext after bad key", exts, 0);

        // R3 R5 R6 sweep of source select and high preload
        for (int s = 0; s < 4; s++) begin
            for (int h = 0; h < 4; h++) begin
                wr(2'd1, 12'hD3A, 20'(s | (h << 2)));
                wr(2'd0, 12'hD3A, 20'h5);
                restart();
                wait_irq(2000, n);
                chk($sformatf("R5 R4 first period s%0d h%0d", s, h), n, (h + 1) * LOWN * (1 << s));
                @(negedge clk);
                chk("R9 irq one cycle", int'(wd_irq_o), 0);
                wait_irq(2000, m);
                chk($sformatf("R6 second period s%0d h%0d", s, h), m + 1, (h + 1) * LOWN * (1 << s));
            end
        end

        // R2 bad-key clock write leaves period unchanged (s0 h0 -> 16)
        wr(2'd1, 12'hD3A, 20'h0);
        wr(2'd1, 12'h2C5, 20'hF);
        restart();
        wait_irq(2000, n);
        chk("R2 period after bad clock key", n, LOWN);

        // R11 keyed restart mid-period gives a full new period (s0 h1 -> 32)
        wr(2'd1, 12'hD3A, 20'h4);
        restart();
        repeat (10) @(negedge clk);
        restart();
        wait_irq(2000, n);
        chk("R11 early restart full period", n, 2 * LOWN);

        // R11 wrong control code ignored: 10 waits + 2 write cycles + rest = 32
        restart();
        repeat (10) @(negedge clk);
        wr(2'd2, 12'hD3A, 20'h0005A);
        wait_irq(2000, n);
        chk("R11 wrong code ignored", n + 12, 2 * LOWN);

        // R7 stop/run: period 16, 6 ticking edges, 22 stopped, restart from n=29, overflow at 38
        wr(2'd1, 12'hD3A, 20'h0);
        restart();
        repeat (5) @(negedge clk);
        wr(2'd0, 12'hD3A, 20'h4);
        irqs = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            irqs += int'(wd_irq_o);
        end
        wr(2'd0, 12'hD3A, 20'h5);
        wait_irq(2000, n);
        chk("R7 no overflow while stopped", irqs, 0);
        chk("R7 delay equals stopped time", n, 9);

        // R8 R10 reset and external outputs, interrupt disabled (s1 h0 -> 32)
        wr(2'd1, 12'hD3A, 20'h1);
        wr(2'd0, 12'hD3A, 20'hB);
        restart();
        irqs = 0; rsts = 0; exts = 0; first_rst = -1; first_ext = -1;
        for (int i = 1; i <= 50; i++) begin
            @(negedge clk);
            irqs += int'(wd_irq_o);
            rsts += int'(wd_rst_o);
            exts += int'(!wd_ext_n_o);
            if (wd_rst_o && first_rst < 0) first_rst = i;
            if (!wd_ext_n_o && first_ext < 0) first_ext = i;
        end
        chk("R8 rst time", first_rst, 2 * LOWN);
        chk("R8 rst width", rsts, 1);
        chk("R10 ext time", first_ext, 2 * LOWN);
        chk("R10 ext width", exts, 8);
        chk("R9 irq silent when disabled", irqs, 0);

        summary();
        $finish;
    end

endmodule